// File: doc/BRIEF.md
# Periodic Interval Timer with Software-Assigned Interrupt Number

This block is a per-CPU periodic interval timer on a small register bus. Software loads a 32-bit throttle value, the length of one interval in bus clock cycles, and then writes a control word that enables the timer. The same word carries a 6-bit interrupt number and a 4-bit legacy priority field. Once enabled, the timer emits a one-cycle interrupt request every throttle interval. Each request travels with an interrupt number toward the interrupt controller. That number is the programmed number with the priority field ORed onto its bits 2 to 5.

A read-only register returns the bus clock period in nanoseconds, so that software can convert a time interval into a throttle count. A live count register shows how far the current interval has progressed. To reprogram the timer, software writes zero to the control register, writes the new throttle, and then writes the control word with enable set.

A two-state machine drives the interval counter. The state ST_OFF holds the counter at zero. The transition "arm" goes from ST_OFF to ST_RUN on an enabling control write. The transition "restart" stays in ST_RUN on a further enabling write and clears the counter. The transition "halt" goes from ST_RUN to ST_OFF when enable is cleared.

Top module: `interval_timer`

## Requirements
- R1: After reset, the control, throttle and count registers read 0 and `irq_req` is low.
- R2: The control register at offset 0x00 stores the enable bit (bit 26), the interrupt number (bits 17:12) and the priority (bits 23:20). All other bits read back as 0.
- R3: The throttle register at offset 0x10 stores and reads back all 32 bits.
- R4: Offset 0x18 reads the constant `BUS_NS`. Writes to it have no effect. Read data appears on `rd_data` in the cycle after the edge that samples `rd_en`.
- R5: Let edge E capture an enabling control write, with throttle T ≥ 1. `irq_req` is then high for exactly one cycle after edge E+1+T, and again after every further T edges.
- R6: A throttle of 0 behaves as a throttle of 1. The request then fires on every cycle.
- R7: A control write with bit 26 clear, captured at edge D, blocks any request from edge D onward.
- R8: An enabling control write while the timer is running restarts the interval. The next request follows the R5 timing counted from that write, and any pending expiry of the old interval is dropped.
- R9: While `irq_req` is high, `irq_id` equals the interrupt number ORed with the priority field shifted left by 2. `irq_id` changes only after a bus write.
- R10: The count register at offset 0x14 reads the number of edges since the restart edge E+1 within the current interval. It reads 0 while the timer is disabled, and writes to it have no effect.
- R11: Unmapped offsets (for example 0x04) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_id | output | IRQ_W | Interrupt number sent with the request |

## Verification
The scoreboard predicts the exact cycle of every request. A timer that is off by one edge at arming, or one that counts T+1 cycles per period, lands its pulses on the wrong cycles and is reported. With a zero throttle, a design that treats 0 as a huge count goes silent instead of firing on every cycle. A mid-interval re-enable checks that the old expiry never shows up; a counter that is not cleared produces an early pulse. The bench also checks that a disable write suppresses a pulse due on that very edge, that the OR of the priority field lands on bits 2 to 5 of the interrupt number, and that writes to the read-only offsets leave them unchanged.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_THR    = 'h10;
    localparam int OFF_CNT    = 'h14;
    localparam int OFF_PERIOD = 'h18;

    localparam int EN_BIT   = 26;
    localparam int NUM_LSB  = 12;
    localparam int PRIO_LSB = 20;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int IRQ_W  = 6,
    parameter int PRIO_W = 4,
    parameter int BUS_NS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rd_data,
    output logic              en_q,
    output logic              restart_q,
    output logic [IRQ_W-1:0]  num_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic [CNT_W-1:0]  thr_q
);
    logic hit_ctrl, hit_thr, hit_cnt, hit_per;
    logic [DATA_W-1:0] rd_mux;

    assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
    assign hit_thr  = (addr == ADDR_W'(OFF_THR));
    assign hit_cnt  = (addr == ADDR_W'(OFF_CNT));
    assign hit_per  = (addr == ADDR_W'(OFF_PERIOD));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            restart_q <= 1'b0;
            num_q     <= '0;
            prio_q    <= '0;
            thr_q     <= '0;
        end else begin
            restart_q <= wr_en && hit_ctrl && wr_data[EN_BIT];
            if (wr_en && hit_ctrl) begin
                en_q   <= wr_data[EN_BIT];
                num_q  <= wr_data[NUM_LSB +: IRQ_W];
                prio_q <= wr_data[PRIO_LSB +: PRIO_W];
            end
            if (wr_en && hit_thr) begin
                thr_q <= wr_data[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[EN_BIT]               = en_q;
            rd_mux[NUM_LSB +: IRQ_W]     = num_q;
            rd_mux[PRIO_LSB +: PRIO_W]   = prio_q;
        end else if (hit_thr) begin
            rd_mux = DATA_W'(thr_q);
        end else if (hit_cnt) begin
            rd_mux = DATA_W'(cnt);
        end else if (hit_per) begin
            rd_mux = DATA_W'(BUS_NS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/itmr_ctr.sv
module itmr_ctr
    import itmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             pulse_q
);
    tmr_state_e state_q, state_d;
    logic [CNT_W-1:0] last;

    assign last = (thr == '0) ? '0 : thr - 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en && restart) state_d = ST_RUN;
            ST_RUN: if (!en)           state_d = ST_OFF;
            default:                   state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (!en || restart) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (state_q == ST_RUN) begin
            if (cnt_q >= last) begin
                cnt_q   <= '0;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end
endmodule

// File: rtl/itmr_irqform.sv
module itmr_irqform #(
    parameter int IRQ_W    = 6,
    parameter int PRIO_W   = 4,
    parameter int PRIO_POS = 2
) (
    input  logic [IRQ_W-1:0]  num,
    input  logic [PRIO_W-1:0] prio,
    output logic [IRQ_W-1:0]  id
);
    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (i >= PRIO_POS && i < PRIO_POS + PRIO_W) begin : g_or
            assign id[i] = num[i] | prio[i-PRIO_POS];
        end else begin : g_pass
            assign id[i] = num[i];
        end
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int ADDR_W   = 5,
    parameter int IRQ_W    = 6,
    parameter int PRIO_W   = 4,
    parameter int PRIO_POS = 2,
    parameter int BUS_NS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              irq_req,
    output logic [IRQ_W-1:0]  irq_id
);
    localparam int DATA_W = 32;
    localparam int CNT_W  = 32;

    logic              en_q, restart_q, pulse_q;
    logic [IRQ_W-1:0]  num_q;
    logic [PRIO_W-1:0] prio_q;
    logic [CNT_W-1:0]  thr_q, cnt_q;

    itmr_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .IRQ_W(IRQ_W), .PRIO_W(PRIO_W), .BUS_NS(BUS_NS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .cnt(cnt_q), .rd_data(rd_data),
        .en_q(en_q), .restart_q(restart_q), .num_q(num_q),
        .prio_q(prio_q), .thr_q(thr_q)
    );

    itmr_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .en(en_q), .restart(restart_q),
        .thr(thr_q), .cnt_q(cnt_q), .pulse_q(pulse_q)
    );

    itmr_irqform #(.IRQ_W(IRQ_W), .PRIO_W(PRIO_W), .PRIO_POS(PRIO_POS)) u_form (
        .num(num_q), .prio(prio_q), .id(irq_id)
    );

    // a disable captured on the same edge as an expiry wins
    assign irq_req = pulse_q & en_q;
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
    parameter int ADDR_W = 5,
    parameter int IRQ_W  = 6,
    parameter int BUS_NS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              irq_req,
    input logic [IRQ_W-1:0]  irq_id,
    input logic              en_q,
    input logic [31:0]       thr_q,
    input logic [31:0]       cnt_q
);
    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && thr_q > 32'd1 && !wr_en) |=> !irq_req);

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_req);

    // R9
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(irq_id));

    // R4
    period_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'('h18)) |=> rd_data == 32'(BUS_NS));

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !$past(en_q)) |-> cnt_q == 32'd0);
endmodule

bind interval_timer itmr_chk #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .BUS_NS(BUS_NS)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .irq_req(irq_req), .irq_id(irq_id), .en_q(en_q),
    .thr_q(thr_q), .cnt_q(cnt_q)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
    localparam int ADDR_W = 5;
    localparam int BUS_NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic irq_req;
    logic [5:0] irq_id;

    int total = 0, bad = 0, cyc = 0;
    int exp_q[$];
    logic [5:0] exp_id = '0;
    string cur_req = "R5";
    bit mon_on = 1'b0;
    bit done = 1'b0;

    interval_timer #(.ADDR_W(ADDR_W), .BUS_NS(BUS_NS)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq_req(irq_req), .irq_id(irq_id)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog: cycle=%0d expected completion before 20000", cyc);
            finish_run();
        end
    end

    // monitor: pops predicted pulse cycles and compares with the design
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                total++;
                if (!irq_req || irq_id != exp_id) begin
                    bad++;
                    $display("FAIL %s cycle %0d: req=%0b id=%0h expected req=1 id=%0h",
                             cur_req, cyc, irq_req, irq_id, exp_id);
                end
                void'(exp_q.pop_front());
            end else if (irq_req) begin
                total++; bad++;
                $display("FAIL %s cycle %0d: req=1 expected req=0", cur_req, cyc);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d, output int e);
        addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        e = cyc;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] v, output int e);
        addr = ADDR_W'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
        e = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input logic [5:0] num, input logic [3:0] prio);
        return (32'(en) << 26) | (32'(num) << 12) | (32'(prio) << 20);
    endfunction

    task automatic run_periodic(input logic [31:0] thr, input logic [5:0] num,
                                input logic [3:0] prio, input int n, input string req);
        int e, d, teff;
        cur_req = req;
        bus_wr('h10, thr, e);
        exp_id = num | {prio, 2'b00};
        bus_wr('h00, ctrl_word(1'b1, num, prio), e);
        teff = (thr == 0) ? 1 : int'(thr);
        for (int k = 1; k <= n; k++) exp_q.push_back(e + 1 + k * teff);
        wait_until(e + 1 + n * teff);
        cur_req = "R7";
        bus_wr('h00, 32'h0, d);
        idle(2 * teff + 4);
        check(exp_q.size() == 0, "R7", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        logic [31:0] v, v2;
        int e, e2, a, b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R1 reset state
        check(irq_req == 1'b0, "R1 irq", 32'(irq_req), 32'h0);
        bus_rd('h00, v, a); check(v == 0, "R1 ctrl", v, 32'h0);
        bus_rd('h10, v, a); check(v == 0, "R1 thr", v, 32'h0);
        bus_rd('h14, v, a); check(v == 0, "R1 cnt", v, 32'h0);

        // R4 bus period register
        bus_rd('h18, v, a); check(v == BUS_NS, "R4 read", v, 32'(BUS_NS));
        bus_wr('h18, 32'hDEAD_BEEF, e);
        bus_rd('h18, v, a); check(v == BUS_NS, "R4 after write", v, 32'(BUS_NS));

        // R11 unmapped offset
        bus_rd('h04, v, a); check(v == 0, "R11", v, 32'h0);

        // R2 control fields, enable clear so no pulses
        bus_wr('h00, 32'hFBFF_FFFF, e);
        bus_rd('h00, v, a); check(v == 32'h00F3_F000, "R2", v, 32'h00F3_F000);
        bus_wr('h00, 32'h0, e);

        // R3 throttle width
        bus_wr('h10, 32'hA5A5_5A5A, e);
        bus_rd('h10, v, a); check(v == 32'hA5A5_5A5A, "R3", v, 32'hA5A5_5A5A);

        // R5 / R9 periodic firing with priority OR
        run_periodic(32'd5, 6'h21, 4'h9, 4, "R5 R9");
        run_periodic(32'd3, 6'h02, 4'h0, 3, "R5");
        run_periodic(32'd7, 6'h00, 4'hF, 2, "R9");

        // R6 zero and one throttles
        run_periodic(32'd0, 6'h15, 4'h0, 3, "R6");
        run_periodic(32'd1, 6'h0A, 4'h1, 3, "R6");

        // R8 restart mid-interval drops the old expiry
        cur_req = "R8";
        bus_wr('h10, 32'd10, e);
        exp_id = 6'h11;
        bus_wr('h00, ctrl_word(1'b1, 6'h11, 4'h0), e);
        exp_q.push_back(e + 11);
        wait_until(e + 6);
        exp_q.delete();
        bus_wr('h00, ctrl_word(1'b1, 6'h11, 4'h0), e2);
        exp_q.push_back(e2 + 11);
        exp_q.push_back(e2 + 21);
        wait_until(e2 + 21);
        bus_wr('h00, 32'h0, e);
        idle(25);
        check(exp_q.size() == 0, "R8", 32'(exp_q.size()), 32'h0);

        // R10 live count
        bus_wr('h10, 32'd1000, e);
        bus_wr('h00, ctrl_word(1'b1, 6'h01, 4'h0), e);
        idle(20);
        bus_rd('h14, v, a);
        check(v == 32'(a - e - 2), "R10 value", v, 32'(a - e - 2));
        idle(7);
        bus_rd('h14, v2, b);
        check(v2 - v == 32'(b - a), "R10 delta", v2 - v, 32'(b - a));
        bus_wr('h00, 32'h0, e);
        idle(2);
        bus_rd('h14, v, a); check(v == 0, "R10 idle", v, 32'h0);
        bus_wr('h14, 32'h1234_5678, e);
        bus_rd('h14, v, a); check(v == 0, "R10 write ignored", v, 32'h0);

        idle(5);
        finish_run();
    end
endmodule